// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block looks up virtual addresses in a fully associative array of translation entries. Each entry is tagged with a virtual page number and a context number, and it carries its own page-size code, so pages of four sizes can share one array. A write port loads the entries. A lookup request can come from the data side or from the instruction side. One cycle after the request, the block reports exactly one of four outcomes: a hit with a physical address and write permission, a protection trap, a fault trap, or a miss. Refill on a miss and the choice of victim entry are left to the surrounding logic.

On each fault, protection trap or miss, a set of status registers is updated. A fault-status word records why the access failed and whether an earlier failure was never cleared. A fault-address register keeps the virtual address. A tag-access register holds the page-aligned address merged with the context. Each entry also has a used flag, which a successful translation sets and a write to that entry clears.

Top module: `tlb_xlate`

## Requirements
- R1: Page-size code 0, 1, 2 or 3 selects 8 KB, 64 KB, 512 KB or 4 MB. An entry matches when its valid attribute is set, its stored virtual address equals the request address on all bits from 13, 16, 19 or 22 upward (by size code), and either its global attribute is set or its context equals the lookup context. The `wr_attr` bits are: bit0 valid, bit1 global, bit2 privileged, bit3 writable, bit4 side-effect, bit5 no-fault-only.
- R2: On the data side, `req_kind` 0 uses `pri_ctx`, 1 uses `sec_ctx`, and 2 or 3 uses context 0 (nucleus, kind 2). The instruction side uses `pri_ctx` (kind 0) when `tl_nz` is low and context 0 (kind 2) when it is high.
- R3: The hit address takes the entry's physical page above the size mask and the request address below it, limited to 41 bits, with bits 12:0 forced to zero.
- R4: A data hit becomes a fault in any of these cases. The fault-type bits in `fsr` record the cause, and several may be set together:
  - a user access to a privileged page (bit7);
  - a no-fault load to a side-effect page (bit8);
  - any other access to a no-fault-only page (bit9).
- R5: A data store that hits a page without write permission, and has no R4 fault, gives a protection trap and no hit.
- R6: On a fault or protection trap, `fsr` is rewritten as follows:
  - bit0 is set (valid);
  - bit1 is set if bit0 was already set (overflow);
  - bit2 records a store;
  - bit3 records `cpu_priv`;
  - bit4 records a no-fault load;
  - bits 6:5 hold the context kind.
- R7: A fault, protection trap or miss loads `tag_acc` with the request address with bits 12:0 cleared, ORed with the lookup context. A fault or protection trap loads `far` with the full address. A miss leaves `fsr` and `far` unchanged.
- R8: A translated (not bypassed) hit sets that entry's bit in `used_flags`. Writing an entry clears its bit.
- R9: When `xlate_en` is low, or on the instruction side when `recov_mode` is high, the request hits with `rsp_pa` equal to the low 41 address bits. In this bypass, `rsp_wr_ok` is 1 on the data side and 0 on the instruction side.
- R10: When several entries match, the lowest-index entry supplies the result.
- R11: `rsp_vld` follows `req_vld` one cycle later and carries exactly one of hit, fault, protection or miss. After reset, all status registers and used flags are zero.
- R12: On the instruction side, the only check is a user fetch from a privileged page, which faults with bit7. An instruction hit reports `rsp_wr_ok` as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry index to load |
| wr_va | input | 64 | Virtual page address of entry |
| wr_ctx | input | 13 | Context of entry |
| wr_pa | input | 41 | Physical page address of entry |
| wr_size | input | 2 | Page-size code |
| wr_attr | input | 6 | Attribute bits (R1) |
| req_vld | input | 1 | Lookup request |
| req_ifetch | input | 1 | 1 = instruction side |
| req_va | input | 64 | Lookup virtual address |
| req_kind | input | 2 | Data-side context kind |
| req_user | input | 1 | Access made in user mode |
| req_store | input | 1 | Data store |
| req_nf_load | input | 1 | No-fault load |
| cpu_priv | input | 1 | CPU privileged state |
| tl_nz | input | 1 | Trap level nonzero |
| xlate_en | input | 1 | Translation enable |
| recov_mode | input | 1 | Instruction-side recovery state, forces bypass |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| rsp_vld | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Fault trap |
| rsp_prot | output | 1 | Write-protection trap |
| rsp_miss | output | 1 | No entry matched |
| rsp_pa | output | 41 | Physical address on hit |
| rsp_wr_ok | output | 1 | Write permitted on hit |
| fsr | output | 10 | Fault status word |
| far | output | 64 | Fault address |
| tag_acc | output | 64 | Tag-access value |
| used_flags | output | 64 | Per-entry used flags |

## Verification
The hardest state to reach from the ports is a fault word that carries several fault-type bits plus the overflow bit. That needs a page that is both privileged and side-effect, a user no-fault load to it, and an earlier failure that was never cleared. The stimulus builds it with a run of back-to-back faults of different kinds with no reset between them. The first fault must show overflow clear, and every later fault must show it set. Two global entries cover the same page so that priority can be seen in the returned address. The used flags are read only after the whole run, which shows that faults and bypasses did not touch them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int ATTR_W  = 6;
    localparam int AT_VLD  = 0;
    localparam int AT_GLB  = 1;
    localparam int AT_PRV  = 2;
    localparam int AT_WR   = 3;
    localparam int AT_SFX  = 4;
    localparam int AT_NFO  = 5;

    localparam int FSR_W   = 10;

    typedef enum logic [1:0] {
        CK_PRI = 2'd0,
        CK_SEC = 2'd1,
        CK_NUC = 2'd2
    } ctx_kind_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 64,
    parameter int PA_W    = 41,
    parameter int CTX_W   = 13,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [VA_W-1:0]   wr_va,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [PA_W-1:0]   wr_pa,
    input  logic [1:0]        wr_size,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              touch_en,
    input  logic [IW-1:0]     touch_idx,
    output logic [VA_W-1:0]   ent_va   [ENTRIES],
    output logic [CTX_W-1:0]  ent_ctx  [ENTRIES],
    output logic [PA_W-1:0]   ent_pa   [ENTRIES],
    output logic [1:0]        ent_size [ENTRIES],
    output logic [ATTR_W-1:0] ent_attr [ENTRIES],
    output logic [ENTRIES-1:0] used_q
);
    logic [ENTRIES-1:0] used_d;

    always_comb begin
        used_d = used_q;
        if (touch_en) used_d[touch_idx] = 1'b1;
        if (wr_en)    used_d[wr_idx]    = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_va[i]   <= '0;
                ent_ctx[i]  <= '0;
                ent_pa[i]   <= '0;
                ent_size[i] <= '0;
                ent_attr[i] <= '0;
            end
        end else begin
            used_q <= used_d;
            if (wr_en) begin
                ent_va[wr_idx]   <= wr_va;
                ent_ctx[wr_idx]  <= wr_ctx;
                ent_pa[wr_idx]   <= wr_pa;
                ent_size[wr_idx] <= wr_size;
                ent_attr[wr_idx] <= wr_attr;
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int VA_W     = 64,
    parameter int PA_W     = 41,
    parameter int CTX_W    = 13,
    parameter int PG_SHIFT = 13,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic [VA_W-1:0]   va,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [VA_W-1:0]   ent_va   [ENTRIES],
    input  logic [CTX_W-1:0]  ent_ctx  [ENTRIES],
    input  logic [PA_W-1:0]   ent_pa   [ENTRIES],
    input  logic [1:0]        ent_size [ENTRIES],
    input  logic [ATTR_W-1:0] ent_attr [ENTRIES],
    output logic              m_any,
    output logic [IW-1:0]     m_idx,
    output logic [PA_W-1:0]   m_pa,
    output logic [ATTR_W-1:0] m_attr
);
    logic [VA_W-1:0]    mask_v [ENTRIES];
    logic [ENTRIES-1:0] hit_v;
    logic [VA_W-1:0]    sel_mask;
    logic [VA_W-1:0]    pa_ext;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        always_comb begin
            mask_v[g] = ~((VA_W'(1) << (PG_SHIFT + 3 * int'(ent_size[g]))) - VA_W'(1));
            hit_v[g]  = ent_attr[g][AT_VLD]
                      && (((va ^ ent_va[g]) & mask_v[g]) == '0)
                      && (ent_attr[g][AT_GLB] || (ent_ctx[g] == ctx));
        end
    end

    always_comb begin
        m_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_v[i]) m_idx = IW'(i);
        end
        m_any    = |hit_v;
        m_attr   = ent_attr[m_idx];
        sel_mask = mask_v[m_idx];
        pa_ext   = ({{(VA_W-PA_W){1'b0}}, ent_pa[m_idx]} & sel_mask) | (va & ~sel_mask);
        m_pa     = {pa_ext[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int VA_W     = 64,
    parameter int PA_W     = 41,
    parameter int CTX_W    = 13,
    parameter int PG_SHIFT = 13,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [VA_W-1:0]    wr_va,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic [PA_W-1:0]    wr_pa,
    input  logic [1:0]         wr_size,
    input  logic [ATTR_W-1:0]  wr_attr,
    input  logic               req_vld,
    input  logic               req_ifetch,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic               req_store,
    input  logic               req_nf_load,
    input  logic               cpu_priv,
    input  logic               tl_nz,
    input  logic               xlate_en,
    input  logic               recov_mode,
    input  logic [CTX_W-1:0]   pri_ctx,
    input  logic [CTX_W-1:0]   sec_ctx,
    output logic               rsp_vld,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic               rsp_prot,
    output logic               rsp_miss,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_wr_ok,
    output logic [FSR_W-1:0]   fsr,
    output logic [VA_W-1:0]    far,
    output logic [VA_W-1:0]    tag_acc,
    output logic [ENTRIES-1:0] used_flags
);
    typedef struct packed {
        logic             vld;
        logic             hit;
        logic             fault;
        logic             prot;
        logic             miss;
        logic [PA_W-1:0]  pa;
        logic             wr_ok;
        logic [FSR_W-1:0] fsr;
        logic [VA_W-1:0]  far;
        logic [VA_W-1:0]  tag;
    } state_t;

    state_t st_d, st_q;

    logic [VA_W-1:0]   ent_va   [ENTRIES];
    logic [CTX_W-1:0]  ent_ctx  [ENTRIES];
    logic [PA_W-1:0]   ent_pa   [ENTRIES];
    logic [1:0]        ent_size [ENTRIES];
    logic [ATTR_W-1:0] ent_attr [ENTRIES];

    ctx_kind_e         kind;
    logic [CTX_W-1:0]  lk_ctx;
    logic              bypass;
    logic              m_any;
    logic [IW-1:0]     m_idx;
    logic [PA_W-1:0]   m_pa;
    logic [ATTR_W-1:0] m_attr;
    logic              touch_en;

    // context selection and bypass decision
    always_comb begin
        if (req_ifetch) begin
            kind   = tl_nz ? CK_NUC : CK_PRI;
            bypass = !xlate_en || recov_mode;
        end else begin
            unique case (req_kind)
                2'd0:    kind = CK_PRI;
                2'd1:    kind = CK_SEC;
                default: kind = CK_NUC;
            endcase
            bypass = !xlate_en;
        end
        unique case (kind)
            CK_PRI:  lk_ctx = pri_ctx;
            CK_SEC:  lk_ctx = sec_ctx;
            default: lk_ctx = '0;
        endcase
    end

    tlb_entry_store #(
        .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_va    (wr_va),
        .wr_ctx   (wr_ctx),
        .wr_pa    (wr_pa),
        .wr_size  (wr_size),
        .wr_attr  (wr_attr),
        .touch_en (touch_en),
        .touch_idx(m_idx),
        .ent_va   (ent_va),
        .ent_ctx  (ent_ctx),
        .ent_pa   (ent_pa),
        .ent_size (ent_size),
        .ent_attr (ent_attr),
        .used_q   (used_flags)
    );

    tlb_match #(
        .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .PG_SHIFT(PG_SHIFT)
    ) i_match (
        .va      (req_va),
        .ctx     (lk_ctx),
        .ent_va  (ent_va),
        .ent_ctx (ent_ctx),
        .ent_pa  (ent_pa),
        .ent_size(ent_size),
        .ent_attr(ent_attr),
        .m_any   (m_any),
        .m_idx   (m_idx),
        .m_pa    (m_pa),
        .m_attr  (m_attr)
    );

    logic ft_priv, ft_sfx, ft_nfo, is_store, is_nfl, any_ft, prot_hit;
    logic [VA_W-1:0] tag_val;

    always_comb begin
        is_store = !req_ifetch && req_store;
        is_nfl   = !req_ifetch && !req_store && req_nf_load;
        ft_priv  = m_attr[AT_PRV] && req_user;
        ft_sfx   = is_nfl && m_attr[AT_SFX];
        ft_nfo   = !req_ifetch && !is_nfl && m_attr[AT_NFO];
        any_ft   = ft_priv || ft_sfx || ft_nfo;
        prot_hit = !any_ft && is_store && !m_attr[AT_WR];
        tag_val  = {req_va[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}} | VA_W'(lk_ctx);

        st_d       = st_q;
        st_d.vld   = req_vld;
        st_d.hit   = 1'b0;
        st_d.fault = 1'b0;
        st_d.prot  = 1'b0;
        st_d.miss  = 1'b0;
        st_d.pa    = '0;
        st_d.wr_ok = 1'b0;
        touch_en   = 1'b0;

        if (req_vld) begin
            if (bypass) begin
                st_d.hit   = 1'b1;
                st_d.pa    = req_va[PA_W-1:0];
                st_d.wr_ok = !req_ifetch;
            end else if (!m_any) begin
                st_d.miss = 1'b1;
                st_d.tag  = tag_val;
            end else if (any_ft || prot_hit) begin
                st_d.fault = any_ft;
                st_d.prot  = prot_hit;
                st_d.fsr   = {ft_nfo, ft_sfx, ft_priv, kind, is_nfl,
                              cpu_priv, is_store, st_q.fsr[0], 1'b1};
                st_d.far   = req_va;
                st_d.tag   = tag_val;
            end else begin
                st_d.hit   = 1'b1;
                st_d.pa    = m_pa;
                st_d.wr_ok = !req_ifetch && m_attr[AT_WR];
                touch_en   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_vld   = st_q.vld;
    assign rsp_hit   = st_q.hit;
    assign rsp_fault = st_q.fault;
    assign rsp_prot  = st_q.prot;
    assign rsp_miss  = st_q.miss;
    assign rsp_pa    = st_q.pa;
    assign rsp_wr_ok = st_q.wr_ok;
    assign fsr       = st_q.fsr;
    assign far       = st_q.far;
    assign tag_acc   = st_q.tag;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VA_W  = 64,
    parameter int PA_W  = 41,
    parameter int FSR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             req_ifetch,
    input logic [VA_W-1:0]  req_va,
    input logic             xlate_en,
    input logic             rsp_vld,
    input logic             rsp_hit,
    input logic             rsp_fault,
    input logic             rsp_prot,
    input logic             rsp_miss,
    input logic [PA_W-1:0]  rsp_pa,
    input logic [FSR_W-1:0] fsr,
    input logic [VA_W-1:0]  far
);
    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);
    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $countones({rsp_hit, rsp_fault, rsp_prot, rsp_miss}) == 1);
    // R7
    miss_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_miss) |-> ($stable(fsr) && $stable(far)));
    // R7
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (!(rsp_fault || rsp_prot) || (far == $past(req_va) && fsr[0])));
    // R6
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && (rsp_fault || rsp_prot) && $past(fsr[0])) |-> fsr[1]);
    // R9
    data_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !xlate_en && !req_ifetch) |=> (rsp_hit && rsp_pa == $past(req_va[PA_W-1:0])));
    // R3
    pa_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && xlate_en && !req_ifetch) |=> (!rsp_hit || rsp_pa[12:0] == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .FSR_W(tlb_pkg::FSR_W)) i_chk (.*);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_va = '0;
    logic [12:0] wr_ctx = '0;
    logic [40:0] wr_pa = '0;
    logic [1:0]  wr_size = '0;
    logic [5:0]  wr_attr = '0;
    logic        req_vld = 1'b0, req_ifetch = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0, req_store = 1'b0, req_nf_load = 1'b0;
    logic        cpu_priv = 1'b0, tl_nz = 1'b0, xlate_en = 1'b1, recov_mode = 1'b0;
    logic [12:0] pri_ctx = 13'd5, sec_ctx = 13'd7;
    logic        rsp_vld, rsp_hit, rsp_fault, rsp_prot, rsp_miss, rsp_wr_ok;
    logic [40:0] rsp_pa;
    logic [9:0]  fsr;
    logic [63:0] far, tag_acc, used_flags;

    always #10 clk = ~clk;

    tlb_xlate i_tlb_xlate (.*);

    typedef struct packed {
        logic ifetch; logic [1:0] kind; logic user, store, nfl, cpriv, tl, en, rec;
    } ctl_t;
    typedef struct {
        string tag; logic [3:0] outc; logic [40:0] pa; logic wok;
        logic [9:0] fsr; logic [63:0] far, tagacc;
    } exp_t;

    localparam logic [3:0] O_HIT = 4'b1000, O_FLT = 4'b0100, O_PRT = 4'b0010, O_MIS = 4'b0001;
    localparam ctl_t DFLT = '{ifetch:1'b0, kind:2'd0, user:1'b0, store:1'b0, nfl:1'b0,
                              cpriv:1'b1, tl:1'b0, en:1'b1, rec:1'b0};

    exp_t q[$];
    int checks = 0, errors = 0;
    logic [9:0]  m_fsr = '0;
    logic [63:0] m_far = '0, m_tag = '0;
    bit done = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                      input logic [40:0] pa, input logic [1:0] sz, input logic [5:0] at);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_va = va; wr_ctx = ctx;
        wr_pa = pa; wr_size = sz; wr_attr = at;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: applies one lookup and pushes the expected result
    task automatic look(input string tag, input ctl_t c, input logic [63:0] va,
                        input logic [3:0] outc, input logic [40:0] pa,
                        input logic wok, input logic [9:0] fbits);
        exp_t e;
        logic [12:0] ctx;
        @(negedge clk);
        req_vld = 1'b1; req_va = va; req_ifetch = c.ifetch; req_kind = c.kind;
        req_user = c.user; req_store = c.store; req_nf_load = c.nfl;
        cpu_priv = c.cpriv; tl_nz = c.tl; xlate_en = c.en; recov_mode = c.rec;
        if (c.ifetch) ctx = c.tl ? 13'd0 : pri_ctx;
        else ctx = (c.kind == 2'd0) ? pri_ctx : (c.kind == 2'd1) ? sec_ctx : 13'd0;
        if (outc == O_FLT || outc == O_PRT) begin
            m_fsr = fbits | 10'h1 | (m_fsr[0] ? 10'h2 : 10'h0);
            m_far = va;
            m_tag = {va[63:13], 13'd0} | 64'(ctx);
        end else if (outc == O_MIS) begin
            m_tag = {va[63:13], 13'd0} | 64'(ctx);
        end
        e.tag = tag; e.outc = outc; e.pa = pa; e.wok = wok;
        e.fsr = m_fsr; e.far = m_far; e.tagacc = m_tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rsp_vld) begin
                exp_t e;
                logic ok;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R11: unexpected response, got outcome %b expected none",
                             {rsp_hit, rsp_fault, rsp_prot, rsp_miss});
                end else begin
                    e = q.pop_front();
                    ok = ({rsp_hit, rsp_fault, rsp_prot, rsp_miss} == e.outc)
                      && (fsr == e.fsr) && (far == e.far) && (tag_acc == e.tagacc);
                    if (e.outc == O_HIT) ok = ok && (rsp_pa == e.pa) && (rsp_wr_ok == e.wok);
                    if (!ok) begin
                        errors++;
                        $display("FAIL %s: got out=%b pa=%h wok=%b fsr=%h far=%h tag=%h expected out=%b pa=%h wok=%b fsr=%h far=%h tag=%h",
                                 e.tag, {rsp_hit, rsp_fault, rsp_prot, rsp_miss}, rsp_pa, rsp_wr_ok,
                                 fsr, far, tag_acc, e.outc, e.pa, e.wok, e.fsr, e.far, e.tagacc);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        ctl_t c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset rsp_vld", 64'(rsp_vld), 64'd0);
        chk("R11 reset fsr", 64'(fsr), 64'd0);
        chk("R11 reset used", used_flags, 64'd0);

        wr(0,  64'h0040_0000,    13'd5, 41'h1_2345_E000, 2'd0, 6'h09);
        wr(1,  64'h8000_0000,    13'd0, 41'h0_4000_0000, 2'd3, 6'h0B);
        wr(2,  64'h1_0000_0000,  13'd5, 41'h2_0000_0000, 2'd1, 6'h05);
        wr(3,  64'h2_0000_0000,  13'd7, 41'h3_0000_0000, 2'd2, 6'h11);
        wr(4,  64'h3000_0000,    13'd0, 41'h5000,        2'd0, 6'h29);
        wr(5,  64'h4000_0000,    13'd5, 41'h6000,        2'd0, 6'h15);
        wr(10, 64'h5000_0000,    13'd9, 41'hA000,        2'd0, 6'h03);
        wr(12, 64'h5000_0000,    13'd9, 41'hB000,        2'd0, 6'h0B);

        c = DFLT;
        look("R1 R3 8K hit", c, 64'h0040_1ABC, O_HIT, 41'h1_2345_E000, 1'b1, 10'h0);
        c = DFLT; c.user = 1; c.store = 1; c.cpriv = 0;
        look("R1 4M global store", c, 64'h8012_3456, O_HIT, 41'h0_4012_2000, 1'b1, 10'h0);
        c = DFLT; c.kind = 2'd1;
        look("R2 secondary ctx mismatch", c, 64'h0040_1ABC, O_MIS, '0, 1'b0, 10'h0);
        look("R2 R3 secondary 512K", c, 64'h2_0007_FFFF, O_HIT, 41'h3_0007_E000, 1'b0, 10'h0);
        c = DFLT;
        look("R1 64K kernel load", c, 64'h1_0000_A123, O_HIT, 41'h2_0000_A000, 1'b0, 10'h0);
        c = DFLT; c.user = 1; c.cpriv = 0;
        look("R4 user to priv", c, 64'h1_0000_A123, O_FLT, '0, 1'b0, 10'h080);
        c = DFLT; c.store = 1;
        look("R5 R6 store to read-only", c, 64'h1_0000_B000, O_PRT, '0, 1'b0, 10'h00C);
        c = DFLT; c.kind = 2'd1; c.nfl = 1;
        look("R4 R6 nf load side-effect", c, 64'h2_0001_0000, O_FLT, '0, 1'b0, 10'h138);
        c = DFLT; c.kind = 2'd2;
        look("R4 R2 nfo page nucleus", c, 64'h3000_0010, O_FLT, '0, 1'b0, 10'h248);
        c = DFLT; c.user = 1; c.nfl = 1; c.cpriv = 0;
        look("R4 multiple fault bits", c, 64'h4000_0020, O_FLT, '0, 1'b0, 10'h190);
        c = DFLT;
        look("R10 lowest index wins", c, 64'h5000_0123, O_HIT, 41'hA000, 1'b0, 10'h0);
        look("R7 miss keeps status", c, 64'h7000_1234, O_MIS, '0, 1'b0, 10'h0);
        c = DFLT; c.en = 0;
        look("R9 data bypass", c, 64'hFFFF_FFFF_1234_5678, O_HIT, 41'h1FF_1234_5678, 1'b1, 10'h0);
        c = DFLT; c.ifetch = 1; c.rec = 1;
        look("R9 ifetch recovery bypass", c, 64'hFFFF_FFFF_1234_5678, O_HIT, 41'h1FF_1234_5678, 1'b0, 10'h0);
        c = DFLT; c.ifetch = 1; c.tl = 1;
        look("R12 R2 ifetch nucleus miss", c, 64'h0040_1000, O_MIS, '0, 1'b0, 10'h0);
        c = DFLT; c.ifetch = 1;
        look("R12 ifetch primary hit", c, 64'h0040_1000, O_HIT, 41'h1_2345_E000, 1'b0, 10'h0);
        c = DFLT; c.ifetch = 1; c.user = 1; c.cpriv = 0; c.nfl = 1;
        look("R12 ifetch priv fault", c, 64'h1_0000_C000, O_FLT, '0, 1'b0, 10'h080);
        idle();
        repeat (3) @(negedge clk);
        chk("R11 queue drained", 64'(q.size()), 64'd0);
        chk("R8 used after hits", used_flags, 64'h40F);
        wr(10, 64'h5000_0000, 13'd9, 41'hA000, 2'd0, 6'h03);
        chk("R8 write clears used", used_flags, 64'h00F);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule